// File: doc/BRIEF.md
# Control Endpoint Handshake Engine

This block holds the device-side handshake state of one control endpoint. An upstream packet layer has already recognised the token and data phases; it presents each one as a single-cycle event tagged SETUP, OUT or IN. On the next clock the block answers with the handshake the endpoint returns: ACK, NAK, STALL, or "send the committed payload". The payload is a zero-length packet (ZLP) when firmware committed nothing.

The single payload bank is modelled only as free or full. This is tracked through four firmware-visible flags:

- a setup-received flag,
- an OUT-received flag,
- an IN-ready flag,
- a NAK-on-IN flag.

Firmware clears flags with a write-one-to-clear strobe. It can also request or withdraw a stall, and it sets one interrupt enable per flag. A bank-control write path exists for uniformity with other endpoint kinds. On this endpoint it is inert and always reads as zero.

Top module: `ctrl_ep_engine`

## Requirements
- R1: An event with kind 2'b01 (SETUP) is always answered ACK (hs_code 3'd1), whatever the stall request and bank state. It sets flags[0] (setup received) and leaves flags[1] (OUT received) unchanged.
- R2: A SETUP event clears stall_req on the same edge, even if fw_stall_set is high in that cycle. Otherwise fw_stall_set sets stall_req and fw_stall_clr clears it, and set wins when both are high.
- R3: An OUT event (kind 2'b10) with flags[1] clear and stall_req clear is answered ACK and sets flags[1].
- R4: An OUT event while flags[1] is set is answered NAK (hs_code 3'd2), even when stall_req is set, and it changes no flag.
- R5: STALL (hs_code 3'd3) is answered only when stall_req is set and the event needs no retry. This means an OUT with flags[1] clear, or an IN with flags[2] clear. A stalled event changes no flag.
- R6: An IN event (kind 2'b11) while flags[2] (IN ready) is set is answered NAK, even when stall_req is set, and it sets flags[3] (NAK on IN).
- R7: Clearing flags[2] commits the bank. The next IN event without stall_req is answered DATA (hs_code 3'd4) with no NAK before it, and it sets flags[2] again.
- R8: fw_clr_wr with fw_clr_mask clears each flag whose mask bit is 1 and leaves the others unchanged. A flag that hardware sets in the same cycle stays set.
- R9: fw_bank_wr and fw_bank_data have no effect on any output, and bank_ctl_rd always reads 2'b00.
- R10: fw_ien_wr loads ien from fw_ien_data. irq is high exactly when some flag is set whose ien bit is set.
- R11: After reset, flags is 4'b0100, ien is 0, stall_req is 0 and hs_valid is 0.
- R12: hs_valid pulses for one cycle, on the clock after each event with a non-zero kind. Kind 2'b00 produces no handshake and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | Event strobe from the packet layer |
| evt_kind | input | 2 | 01 SETUP, 10 OUT, 11 IN, 00 idle |
| fw_clr_wr | input | 1 | Flag clear strobe |
| fw_clr_mask | input | 4 | Write-one-to-clear mask over flags |
| fw_stall_set | input | 1 | Request stall |
| fw_stall_clr | input | 1 | Withdraw stall |
| fw_ien_wr | input | 1 | Interrupt-enable write strobe |
| fw_ien_data | input | 4 | New interrupt-enable value |
| fw_bank_wr | input | 1 | Bank-control write strobe (inert) |
| fw_bank_data | input | 2 | Bank-control write data (inert) |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 3 | 0 none, 1 ACK, 2 NAK, 3 STALL, 4 DATA |
| flags | output | 4 | {NAK-on-IN, IN ready, OUT received, setup received} |
| ien | output | 4 | Interrupt enables, same bit order as flags |
| stall_req | output | 1 | Stall request state |
| bank_ctl_rd | output | 2 | Bank-control readback, always zero |
| irq | output | 1 | Interrupt request |

## Verification
The handshake decision is tried in several directed sequences:

- A full control write: SETUP, then OUT, then the status IN answered directly with a ZLP.
- A control read: SETUP, then IN answered with NAK until firmware commits the bank.
- Each event kind issued with a stall pending, both with and without a retry condition. This separates retry-over-stall from plain stall.
- SETUP issued while stalled and while the OUT bank is full, which shows SETUP bypasses both.

Same-cycle set and clear collisions, and inert bank-control writes, are driven on purpose. A long pseudo-random mix of events and firmware writes is then compared on every clock against a behavioural model of the flag and stall rules.

// File: rtl/ctrl_ep_pkg.sv
// Shared encodings for the control endpoint handshake engine.
package ctrl_ep_pkg;
    localparam int NUM_FLAGS = 4;
    localparam int HS_W      = 3;
    localparam int KIND_W    = 2;
    localparam int BANK_W    = 2;

    // Flag positions (firmware decodes them).
    localparam int F_SETUP = 0;
    localparam int F_OUT   = 1;
    localparam int F_INRDY = 2;
    localparam int F_NAKIN = 3;

    // Reset value of the flag vector: only the IN bank is free.
    localparam logic [NUM_FLAGS-1:0] FLAG_RST = 4'b0100;

    typedef enum logic [KIND_W-1:0] {
        EV_IDLE  = 2'b00,
        EV_SETUP = 2'b01,
        EV_OUT   = 2'b10,
        EV_IN    = 2'b11
    } evt_e;

    typedef enum logic [HS_W-1:0] {
        HS_NONE  = 3'd0,
        HS_ACK   = 3'd1,
        HS_NAK   = 3'd2,
        HS_STALL = 3'd3,
        HS_DATA  = 3'd4
    } hs_e;
endpackage

// File: rtl/ctrl_ep_decide.sv
// Handshake decision for one event.
// Purely combinational; assumes flags and stall are the registered state
// seen before the event. Retry (NAK) outranks stall; SETUP bypasses both.
module ctrl_ep_decide
    import ctrl_ep_pkg::*;
(
    input  logic                 evt_valid,
    input  logic [KIND_W-1:0]    evt_kind,
    input  logic [NUM_FLAGS-1:0] flags_q,
    input  logic                 stall_q,
    output logic                 hs_fire,
    output logic [HS_W-1:0]      hs_next,
    output logic [NUM_FLAGS-1:0] flag_set,
    output logic                 setup_seen
);
    evt_e kind;
    assign kind = evt_e'(evt_kind);

    // Choose the handshake and the flags the event raises.
    always_comb begin
        hs_fire    = 1'b0;
        hs_next    = HS_NONE;
        flag_set   = '0;
        setup_seen = 1'b0;
        if (evt_valid) begin
            unique case (kind)
                EV_SETUP: begin
                    hs_fire           = 1'b1;
                    hs_next           = HS_ACK;
                    flag_set[F_SETUP] = 1'b1;
                    setup_seen        = 1'b1;
                end
                EV_OUT: begin
                    hs_fire = 1'b1;
                    if (flags_q[F_OUT]) begin
                        hs_next = HS_NAK;
                    end else if (stall_q) begin
                        hs_next = HS_STALL;
                    end else begin
                        hs_next         = HS_ACK;
                        flag_set[F_OUT] = 1'b1;
                    end
                end
                EV_IN: begin
                    hs_fire = 1'b1;
                    if (flags_q[F_INRDY]) begin
                        hs_next           = HS_NAK;
                        flag_set[F_NAKIN] = 1'b1;
                    end else if (stall_q) begin
                        hs_next = HS_STALL;
                    end else begin
                        hs_next           = HS_DATA;
                        flag_set[F_INRDY] = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ctrl_ep_flag_bank.sv
// Firmware-visible flags with interrupt enables.
// Hardware set wins over a firmware clear in the same cycle.
// Assumes synchronous active-low reset.
module ctrl_ep_flag_bank
    import ctrl_ep_pkg::*;
#(
    parameter int                 N       = NUM_FLAGS,
    parameter logic [N-1:0]       RST_VAL = FLAG_RST
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hw_set,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    input  logic         ien_wr,
    input  logic [N-1:0] ien_data,
    output logic [N-1:0] flags_q,
    output logic [N-1:0] ien_q,
    output logic         irq
);
    logic [N-1:0] clr_vec;
    assign clr_vec = clr_wr ? clr_mask : '0;

    for (genvar i = 0; i < N; i++) begin : g_flag
        // One flag: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          flags_q[i] <= RST_VAL[i];
            else if (hw_set[i])  flags_q[i] <= 1'b1;
            else if (clr_vec[i]) flags_q[i] <= 1'b0;
        end
    end

    // Interrupt-enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (ien_wr) ien_q <= ien_data;
    end

    assign irq = |(flags_q & ien_q);
endmodule

// File: rtl/ctrl_ep_engine.sv
// Top of the control endpoint handshake engine.
// Registers one handshake per event, keeps the stall request, and exposes
// an inert bank-control readback. Synchronous active-low reset.
module ctrl_ep_engine
    import ctrl_ep_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_valid,
    input  logic [KIND_W-1:0]    evt_kind,
    input  logic                 fw_clr_wr,
    input  logic [NUM_FLAGS-1:0] fw_clr_mask,
    input  logic                 fw_stall_set,
    input  logic                 fw_stall_clr,
    input  logic                 fw_ien_wr,
    input  logic [NUM_FLAGS-1:0] fw_ien_data,
    input  logic                 fw_bank_wr,
    input  logic [BANK_W-1:0]    fw_bank_data,
    output logic                 hs_valid,
    output logic [HS_W-1:0]      hs_code,
    output logic [NUM_FLAGS-1:0] flags,
    output logic [NUM_FLAGS-1:0] ien,
    output logic                 stall_req,
    output logic [BANK_W-1:0]    bank_ctl_rd,
    output logic                 irq
);
    logic                 hs_fire;
    logic [HS_W-1:0]      hs_next;
    logic [NUM_FLAGS-1:0] flag_set;
    logic                 setup_seen;
    logic                 stall_q;
    logic [NUM_FLAGS-1:0] flags_q;

    ctrl_ep_decide u_decide (
        .evt_valid  (evt_valid),
        .evt_kind   (evt_kind),
        .flags_q    (flags_q),
        .stall_q    (stall_q),
        .hs_fire    (hs_fire),
        .hs_next    (hs_next),
        .flag_set   (flag_set),
        .setup_seen (setup_seen)
    );

    ctrl_ep_flag_bank #(.N(NUM_FLAGS), .RST_VAL(FLAG_RST)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_set   (flag_set),
        .clr_wr   (fw_clr_wr),
        .clr_mask (fw_clr_mask),
        .ien_wr   (fw_ien_wr),
        .ien_data (fw_ien_data),
        .flags_q  (flags_q),
        .ien_q    (ien),
        .irq      (irq)
    );

    // Stall request: SETUP clears it, otherwise firmware set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n)            stall_q <= 1'b0;
        else if (setup_seen)   stall_q <= 1'b0;
        else if (fw_stall_set) stall_q <= 1'b1;
        else if (fw_stall_clr) stall_q <= 1'b0;
    end

    // Handshake output register: one-cycle pulse after each event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_valid <= 1'b0;
            hs_code  <= HS_NONE;
        end else begin
            hs_valid <= hs_fire;
            hs_code  <= hs_fire ? hs_next : HS_NONE;
        end
    end

    // Bank-control fields are meaningless here; writes are dropped.
    logic unused_bank_write;
    assign unused_bank_write = fw_bank_wr ^ (^fw_bank_data);
    assign bank_ctl_rd       = '0;

    assign flags     = flags_q;
    assign stall_req = stall_q;
endmodule

// File: rtl/ctrl_ep_engine_chk.sv
// Property checker for ctrl_ep_engine, attached by bind.
module ctrl_ep_engine_chk
    import ctrl_ep_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 evt_valid,
    input logic [KIND_W-1:0]    evt_kind,
    input logic                 hs_valid,
    input logic [HS_W-1:0]      hs_code,
    input logic [NUM_FLAGS-1:0] flags,
    input logic [NUM_FLAGS-1:0] ien,
    input logic                 stall_req,
    input logic                 irq
);
    AST_SETUP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && evt_kind == EV_SETUP |=> hs_valid && hs_code == HS_ACK && flags[F_SETUP]); // R1
    AST_SETUP_NO_OUT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && evt_kind == EV_SETUP && !flags[F_OUT] |=> !flags[F_OUT]); // R1
    AST_SETUP_UNSTALL: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && evt_kind == EV_SETUP |=> !stall_req); // R2
    AST_OUT_RETRY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && evt_kind == EV_OUT && flags[F_OUT] |=> hs_code == HS_NAK); // R4
    AST_STALL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid && hs_code == HS_STALL |-> $past(stall_req)); // R5
    AST_IN_NAK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && evt_kind == EV_IN && flags[F_INRDY] |=> hs_code == HS_NAK && flags[F_NAKIN]); // R6
    AST_ZLP_NO_NAK: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && evt_kind == EV_IN && !flags[F_INRDY] && !stall_req |=> hs_code == HS_DATA && flags[F_INRDY]); // R7
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags & ien) != '0); // R10
    AST_HS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |-> $past(evt_valid) && $past(evt_kind) != EV_IDLE); // R12
endmodule

bind ctrl_ep_engine ctrl_ep_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_kind  (evt_kind),
    .hs_valid  (hs_valid),
    .hs_code   (hs_code),
    .flags     (flags),
    .ien       (ien),
    .stall_req (stall_req),
    .irq       (irq)
);

// File: tb/ctrl_ep_engine_tb_top.sv
// Bench: directed sequences plus a random mix, compared every clock
// against a behavioural model of the handshake and flag rules.
module ctrl_ep_engine_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_valid = 1'b0;
    logic [1:0] evt_kind = 2'b00;
    logic       fw_clr_wr = 1'b0;
    logic [3:0] fw_clr_mask = 4'b0;
    logic       fw_stall_set = 1'b0;
    logic       fw_stall_clr = 1'b0;
    logic       fw_ien_wr = 1'b0;
    logic [3:0] fw_ien_data = 4'b0;
    logic       fw_bank_wr = 1'b0;
    logic [1:0] fw_bank_data = 2'b0;
    logic       hs_valid;
    logic [2:0] hs_code;
    logic [3:0] flags;
    logic [3:0] ien;
    logic       stall_req;
    logic [1:0] bank_ctl_rd;
    logic       irq;

    always #2.5 clk = ~clk;

    ctrl_ep_engine dut_i (.*);

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    // Reference model state.
    bit [3:0] m_flags = 4'b0100;
    bit [3:0] m_ien   = 4'b0;
    bit       m_stall = 0;
    bit       m_hsv   = 0;
    int       m_hsc   = 0;

    task automatic chk(string tag, int act, int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic model_step();
        bit [3:0] setv = 4'b0;
        bit [3:0] clrv;
        bit setup = 0;
        m_hsv = 0;
        m_hsc = 0;
        if (evt_valid && evt_kind != 2'b00) begin
            m_hsv = 1;
            if (evt_kind == 2'b01) begin
                m_hsc = 1; setv[0] = 1; setup = 1;
            end else if (evt_kind == 2'b10) begin
                if (m_flags[1])   m_hsc = 2;
                else if (m_stall) m_hsc = 3;
                else begin m_hsc = 1; setv[1] = 1; end
            end else begin
                if (m_flags[2])   begin m_hsc = 2; setv[3] = 1; end
                else if (m_stall) m_hsc = 3;
                else begin m_hsc = 4; setv[2] = 1; end
            end
        end
        clrv = fw_clr_wr ? fw_clr_mask : 4'b0;
        for (int i = 0; i < 4; i++)
            if (setv[i]) m_flags[i] = 1;
            else if (clrv[i]) m_flags[i] = 0;
        if (setup)             m_stall = 0;
        else if (fw_stall_set) m_stall = 1;
        else if (fw_stall_clr) m_stall = 0;
        if (fw_ien_wr) m_ien = fw_ien_data;
    endtask

    task automatic compare();
        chk("R12 hs_valid", hs_valid, m_hsv);
        chk("R5 hs_code", hs_code, m_hsc);
        chk("R8 flags", flags, m_flags);
        chk("R10 ien", ien, m_ien);
        chk("R2 stall_req", stall_req, m_stall);
        chk("R10 irq", irq, (m_flags & m_ien) != 0);
        chk("R9 bank_ctl_rd", bank_ctl_rd, 0);
    endtask

    task automatic idle_inputs();
        evt_valid = 0; evt_kind = 0; fw_clr_wr = 0; fw_clr_mask = 0;
        fw_stall_set = 0; fw_stall_clr = 0; fw_ien_wr = 0; fw_ien_data = 0;
        fw_bank_wr = 0; fw_bank_data = 0;
    endtask

    // One clock: inputs already driven, update model at edge, compare after.
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        idle_inputs();
    endtask

    task automatic ev(input logic [1:0] k);
        evt_valid = 1; evt_kind = k; tick();
    endtask

    task automatic clr(input logic [3:0] m);
        fw_clr_wr = 1; fw_clr_mask = m; tick();
    endtask

    // Watchdog: a hang counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        bit [31:0] lfsr = 32'h1d2c3b4a;
        @(negedge clk);
        @(negedge clk);
        // R11 reset state.
        chk("R11 flags", flags, 4'b0100);
        chk("R11 ien", ien, 0);
        chk("R11 stall", stall_req, 0);
        chk("R11 hs_valid", hs_valid, 0);
        rst_n = 1;
        tick();

        // Control write: SETUP, OUT, status IN with a ZLP already committed.
        ev(2'b01);
        chk("R1 setup ack", hs_code, 1);
        chk("R1 setup flag, no out flag", flags & 4'b0011, 4'b0001);
        tick();
        chk("R12 pulse ends", hs_valid, 0);
        clr(4'b0001);
        ev(2'b10);
        chk("R3 out ack", hs_code, 1);
        chk("R3 out flag", flags[1], 1);
        ev(2'b10);
        chk("R4 out retry", hs_code, 2);
        clr(4'b0010);
        clr(4'b0100);                 // commit a ZLP
        ev(2'b11);
        chk("R7 zlp at first IN", hs_code, 4);
        chk("R7 in ready back", flags[2], 1);

        // Control read: IN before commit is NAKed, flag polled.
        ev(2'b01);
        ev(2'b11);
        chk("R6 in nak", hs_code, 2);
        chk("R6 nak flag", flags[3], 1);
        clr(4'b1001);

        // Retry over stall, then plain stall.
        fw_stall_set = 1; tick();
        ev(2'b11);
        chk("R6 nak beats stall", hs_code, 2);
        ev(2'b10);
        chk("R5 out stalled", hs_code, 3);
        chk("R5 stall leaves out flag", flags[1], 0);
        ev(2'b10);                    // still stalled, still no flag
        fw_stall_clr = 1; tick();
        ev(2'b10);
        fw_stall_set = 1; tick();
        ev(2'b10);
        chk("R4 retry beats stall", hs_code, 2);
        clr(4'b0100);
        ev(2'b11);
        chk("R5 in stalled when committed", hs_code, 3);

        // SETUP bypasses stall and a full OUT bank; clears stall.
        fw_stall_set = 1; evt_valid = 1; evt_kind = 2'b01; tick();
        chk("R1 setup ack under stall", hs_code, 1);
        chk("R2 stall cleared by setup", stall_req, 0);

        // Same-cycle hardware set beats firmware clear.
        fw_clr_wr = 1; fw_clr_mask = 4'b0001; evt_valid = 1; evt_kind = 2'b01; tick();
        chk("R8 set beats clear", flags[0], 1);
        clr(4'b0001);
        chk("R8 masked clear", flags[0], 0);

        // Interrupt enables.
        fw_ien_wr = 1; fw_ien_data = 4'b0001; tick();
        chk("R10 irq off", irq, 0);
        ev(2'b01);
        chk("R10 irq on", irq, 1);

        // Bank-control writes are inert.
        fw_bank_wr = 1; fw_bank_data = 2'b11; tick();
        chk("R9 readback zero", bank_ctl_rd, 0);
        chk("R9 flags unchanged", flags, m_flags);

        // Idle kind produces nothing.
        ev(2'b00);
        chk("R12 idle kind", hs_valid, 0);

        // Random mix.
        for (int n = 0; n < 3000; n++) begin
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            evt_valid    = lfsr[31];
            evt_kind     = lfsr[30:29];
            fw_clr_wr    = lfsr[28] & lfsr[27];
            fw_clr_mask  = lfsr[26:23];
            fw_stall_set = lfsr[22] & lfsr[21] & lfsr[20];
            fw_stall_clr = lfsr[19] & lfsr[18];
            fw_ien_wr    = lfsr[17] & lfsr[16] & lfsr[15];
            fw_ien_data  = lfsr[14:11];
            fw_bank_wr   = lfsr[10];
            fw_bank_data = lfsr[9:8];
            tick();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule